// File: doc/BRIEF.md
# Wiper and Preset Register Controller

This block holds the setting of a digitally controlled potentiometer: one volatile wiper register whose 10-bit code drives a downstream tap decoder, and a bank of preset registers modelled as nonvolatile storage. A command decoder upstream presents one command at a time on a strobe with an operation code, a preset index and write data. The block updates the wiper at once, reads either register type combinationally, and runs preset writes as a long, counter-timed store cycle during which it reports busy.

The preset contents survive the synchronous reset. While reset is held, the wiper is reloaded from preset 0, so the last stored default position comes back at every power-up. A low level on the write-protect input blocks every store into the preset bank. A blocked store does not start a busy cycle. A store interrupted by reset leaves the old preset value in place.

Top module: `wiper_preset_ctrl`

## Requirements
- R1: While `rst_n` is low, the wiper is loaded from preset 0, `busy` is 0 and the preset contents are kept. After reset the wiper equals the preset 0 value.
- R2: An accepted write-wiper command (op 1) sets `wiper_code` to `cmd_wdata` at the next clock edge. This holds for any value from 0x000 (low end) to 0x3FF (high end).
- R3: An accepted load command (op 4) copies preset `cmd_idx` into the wiper at the next clock edge.
- R4: The operation codes are: 0 read wiper, 1 write wiper, 2 read preset, 3 write preset, 4 load preset into wiper, 5 save wiper into preset. Codes 6 and 7 do nothing. A read (op 0 or 2) with `cmd_valid` high and `busy` low drives the wiper or preset `cmd_idx` onto `rd_data` in the same cycle. Indices 0 to 3 select presets 0 to 3. Any other command leaves `rd_data` at 0.
- R5: An accepted write-preset command (op 3) with `wp_n` high raises `busy` for exactly NV_CYCLES clock cycles. The preset takes `cmd_wdata` at the edge where `busy` falls.
- R6: A save command (op 5) with `wp_n` high stores the wiper value present when the command was accepted into preset `cmd_idx`, with the same busy timing as R5.
- R7: With `wp_n` low, ops 3 and 5 change no preset and leave `busy` at 0.
- R8: While `busy` is high, every command is ignored: the wiper does not change, no new store starts, and `rd_data` stays 0.
- R9: A reset during a store cycle clears `busy` and leaves the target preset at its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; triggers the preset 0 recall |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Operation code (see R4) |
| cmd_idx | input | 2 | Preset index |
| cmd_wdata | input | 10 | Write data for wiper or preset |
| wp_n | input | 1 | Write protect, low blocks preset stores |
| rd_data | output | 10 | Combinational read data |
| busy | output | 1 | Store cycle in progress |
| wiper_code | output | 10 | Wiper code for the tap decoder |

## Verification
The bench builds the block with NV_CYCLES set to 7 and with distinct preset start values 0x155, 0x2AA, 0x3FF and 0x000. A store cycle therefore completes in a handful of cycles. This lets the bench count the exact busy length, issue commands in the middle of a store, and drop reset partway through one. The distinct start values show which preset a read, load or recall actually touched. The values also cover both end codes of the wiper range.

// File: rtl/wpc_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the wiper and preset register controller.
// Assumes a 3-bit operation field; codes not listed are no-operations.
package wpc_pkg;
    typedef enum logic [2:0] {
        OP_RD_WIPER   = 3'd0,
        OP_WR_WIPER   = 3'd1,
        OP_RD_PRESET  = 3'd2,
        OP_WR_PRESET  = 3'd3,
        OP_LOAD_WIPER = 3'd4,
        OP_SAVE_WIPER = 3'd5
    } op_e;
endpackage

// File: rtl/wpc_cmd_decode.sv
`timescale 1ns/1ps
// Command decoder: turns one command strobe into enables for the wiper,
// the store timer and the read mux. Assumes commands are ignored while busy
// and that a store command is dropped entirely when write protect is low.
module wpc_cmd_decode
    import wpc_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [DATA_W-1:0] wiper_q,
    input  logic              busy,
    input  logic              wp_n,
    output logic              wiper_ld,
    output logic              ld_from_preset,
    output logic              nv_start,
    output logic [DATA_W-1:0] nv_data,
    output logic              rd_wiper_sel,
    output logic              rd_preset_sel
);
    logic accept;

    assign accept = cmd_valid && !busy;

    // Decode the accepted operation into one-hot style enables.
    always_comb begin
        wiper_ld       = 1'b0;
        ld_from_preset = 1'b0;
        nv_start       = 1'b0;
        nv_data        = cmd_wdata;
        rd_wiper_sel   = 1'b0;
        rd_preset_sel  = 1'b0;
        if (accept) begin
            case (op_e'(cmd_op))
                OP_RD_WIPER:   rd_wiper_sel = 1'b1;
                OP_RD_PRESET:  rd_preset_sel = 1'b1;
                OP_WR_WIPER:   wiper_ld = 1'b1;
                OP_LOAD_WIPER: begin
                    wiper_ld       = 1'b1;
                    ld_from_preset = 1'b1;
                end
                OP_WR_PRESET:  nv_start = wp_n;
                OP_SAVE_WIPER: begin
                    nv_start = wp_n;
                    nv_data  = wiper_q;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/wpc_nv_timer.sv
`timescale 1ns/1ps
// Store-cycle timer: holds busy for exactly NV_CYCLES clocks after a start
// and pulses commit in the final busy cycle. Assumes NV_CYCLES >= 1 and
// that start only arrives while idle. Reset aborts a cycle without commit.
module wpc_nv_timer #(
    parameter int NV_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic commit
);
    localparam int CNT_W = $clog2(NV_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    // Load the full cycle count on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CNT_W'(NV_CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign busy   = (cnt != '0);
    assign commit = rst_n && (cnt == CNT_W'(1));
endmodule

// File: rtl/wpc_preset_bank.sv
`timescale 1ns/1ps
// Preset bank: N_PRESET registers that keep their contents through reset
// (power-up values come from PRESET_INIT). A store is captured as pending
// on start and written only at commit. Assumes one store in flight at a time.
module wpc_preset_bank #(
    parameter int DATA_W   = 10,
    parameter int N_PRESET = 4,
    parameter int IDX_W    = 2,
    parameter logic [N_PRESET*DATA_W-1:0] PRESET_INIT = '0
) (
    input  logic              clk,
    input  logic              nv_start,
    input  logic [IDX_W-1:0]  nv_idx,
    input  logic [DATA_W-1:0] nv_data,
    input  logic              commit,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_val,
    output logic [DATA_W-1:0] p0
);
    logic [N_PRESET*DATA_W-1:0] flat;
    logic [IDX_W-1:0]           pend_idx;
    logic [DATA_W-1:0]          pend_data;

    // Capture the target and value of a store when it starts.
    always_ff @(posedge clk) begin
        if (nv_start) begin
            pend_idx  <= nv_idx;
            pend_data <= nv_data;
        end
    end

    for (genvar g = 0; g < N_PRESET; g++) begin : g_preset
        logic [DATA_W-1:0] q = PRESET_INIT[g*DATA_W +: DATA_W];

        // Write the pending value into this preset at commit.
        always_ff @(posedge clk) begin
            if (commit && (pend_idx == IDX_W'(g))) begin
                q <= pend_data;
            end
        end

        assign flat[g*DATA_W +: DATA_W] = q;
    end

    assign rd_val = flat[rd_idx*DATA_W +: DATA_W];
    assign p0     = flat[DATA_W-1:0];
endmodule

// File: rtl/wpc_wiper_reg.sv
`timescale 1ns/1ps
// Volatile wiper register. During reset it reloads from the recall value
// (preset 0); otherwise it takes the load value when enabled.
module wpc_wiper_reg #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] recall_val,
    input  logic              ld,
    input  logic [DATA_W-1:0] ld_val,
    output logic [DATA_W-1:0] q
);
    // Recall at reset, otherwise update on an accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= recall_val;
        end else if (ld) begin
            q <= ld_val;
        end
    end
endmodule

// File: rtl/wiper_preset_ctrl.sv
`timescale 1ns/1ps
// Wiper and preset register controller top. Executes decoded commands
// against one volatile wiper and a nonvolatile-style preset bank with a
// timed store cycle, gated by write protect, with recall of preset 0 at reset.
// Assumes one command per strobe cycle from an upstream decoder.
module wiper_preset_ctrl #(
    parameter int DATA_W    = 10,
    parameter int N_PRESET  = 4,
    parameter int NV_CYCLES = 1000000,
    parameter logic [N_PRESET*DATA_W-1:0] PRESET_INIT = '0,
    localparam int IDX_W    = $clog2(N_PRESET)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              wp_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic [DATA_W-1:0] wiper_code
);
    logic              wiper_ld;
    logic              ld_from_preset;
    logic              nv_start;
    logic [DATA_W-1:0] nv_data;
    logic              rd_wiper_sel;
    logic              rd_preset_sel;
    logic              commit;
    logic [DATA_W-1:0] preset_rd;
    logic [DATA_W-1:0] preset0;
    logic [DATA_W-1:0] ld_val;

    wpc_cmd_decode #(.DATA_W(DATA_W)) u_dec (
        .cmd_valid      (cmd_valid),
        .cmd_op         (cmd_op),
        .cmd_wdata      (cmd_wdata),
        .wiper_q        (wiper_code),
        .busy           (busy),
        .wp_n           (wp_n),
        .wiper_ld       (wiper_ld),
        .ld_from_preset (ld_from_preset),
        .nv_start       (nv_start),
        .nv_data        (nv_data),
        .rd_wiper_sel   (rd_wiper_sel),
        .rd_preset_sel  (rd_preset_sel)
    );

    wpc_nv_timer #(.NV_CYCLES(NV_CYCLES)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (nv_start),
        .busy   (busy),
        .commit (commit)
    );

    wpc_preset_bank #(
        .DATA_W      (DATA_W),
        .N_PRESET    (N_PRESET),
        .IDX_W       (IDX_W),
        .PRESET_INIT (PRESET_INIT)
    ) u_bank (
        .clk      (clk),
        .nv_start (nv_start),
        .nv_idx   (cmd_idx),
        .nv_data  (nv_data),
        .commit   (commit),
        .rd_idx   (cmd_idx),
        .rd_val   (preset_rd),
        .p0       (preset0)
    );

    assign ld_val = ld_from_preset ? preset_rd : cmd_wdata;

    wpc_wiper_reg #(.DATA_W(DATA_W)) u_wiper (
        .clk        (clk),
        .rst_n      (rst_n),
        .recall_val (preset0),
        .ld         (wiper_ld),
        .ld_val     (ld_val),
        .q          (wiper_code)
    );

    // Select the read source for the current command.
    always_comb begin
        if (rd_wiper_sel) begin
            rd_data = wiper_code;
        end else if (rd_preset_sel) begin
            rd_data = preset_rd;
        end else begin
            rd_data = '0;
        end
    end
endmodule

// File: rtl/wpc_checker.sv
`timescale 1ns/1ps
// Property checker for wiper_preset_ctrl, attached with bind below.
// Measures the busy window with a local counter instead of a deep $past.
module wpc_checker
    import wpc_pkg::*;
#(
    parameter int DATA_W    = 10,
    parameter int NV_CYCLES = 1000000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic [DATA_W-1:0] cmd_wdata,
    input logic              wp_n,
    input logic              busy,
    input logic [DATA_W-1:0] wiper_code,
    input logic [DATA_W-1:0] p0
);
    localparam int BC_W = $clog2(NV_CYCLES + 2);

    logic [BC_W-1:0] bcnt;
    logic            seen = 1'b0;

    // Mark that at least one clock edge has passed.
    always_ff @(posedge clk) seen <= 1'b1;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) bcnt <= '0;
        else                 bcnt <= bcnt + BC_W'(1);
    end

    a_r1_recall_p0: assert property (@(posedge clk) disable iff (!seen)
        $past(!rst_n) |-> wiper_code == $past(p0));

    a_r2_wiper_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == OP_WR_WIPER) |=> wiper_code == $past(cmd_wdata));

    a_r5_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && wp_n && cmd_op == OP_WR_PRESET) |=> busy);

    a_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> bcnt == BC_W'(NV_CYCLES));

    a_r7_protect_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && !wp_n &&
         (cmd_op == OP_WR_PRESET || cmd_op == OP_SAVE_WIPER)) |=> !busy);

    a_r8_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |=> $stable(wiper_code));
endmodule

bind wiper_preset_ctrl wpc_checker #(
    .DATA_W    (DATA_W),
    .NV_CYCLES (NV_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_wdata  (cmd_wdata),
    .wp_n       (wp_n),
    .busy       (busy),
    .wiper_code (wiper_code),
    .p0         (preset0)
);

// File: tb/wiper_preset_ctrl_test.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected outputs, a monitor pops
// and compares them against the live ports.
module wiper_preset_ctrl_test;
    localparam int DW = 10;
    localparam int NP = 4;
    localparam int NV = 7;
    localparam logic [NP*DW-1:0] INIT = {10'h000, 10'h3FF, 10'h2AA, 10'h155};

    localparam logic [2:0] RD_W = 3'd0, WR_W = 3'd1, RD_P = 3'd2,
                           WR_P = 3'd3, LD_W = 3'd4, SV_W = 3'd5;
    localparam int K_RD = 0, K_WIPER = 1, K_BUSY = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [1:0]    cmd_idx = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          wp_n = 1'b1;
    logic [DW-1:0] rd_data;
    logic          busy;
    logic [DW-1:0] wiper_code;

    typedef struct {
        string         tag;
        int            kind;
        logic [DW-1:0] exp;
    } item_t;

    item_t q[$];
    event  chk_ev;
    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 1'b0;

    wiper_preset_ctrl #(
        .DATA_W(DW), .N_PRESET(NP), .NV_CYCLES(NV), .PRESET_INIT(INIT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_idx(cmd_idx), .cmd_wdata(cmd_wdata), .wp_n(wp_n),
        .rd_data(rd_data), .busy(busy), .wiper_code(wiper_code)
    );

    always #2.5 clk = ~clk;

    // Monitor: pop queued expectations and compare with the ports.
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                item_t         it;
                logic [DW-1:0] act;
                it = q.pop_front();
                case (it.kind)
                    K_RD:    act = rd_data;
                    K_WIPER: act = wiper_code;
                    default: act = {{(DW-1){1'b0}}, busy};
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_err++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_out(string tag, int kind, logic [DW-1:0] exp);
        q.push_back('{tag, kind, exp});
        ->chk_ev;
        #0.5;
    endtask

    task automatic chk_val(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Present a command for one edge; returns at the following negedge.
    task automatic issue(logic [2:0] op, logic [1:0] idx, logic [DW-1:0] d);
        cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Present a read combinationally and withdraw it before the edge.
    task automatic read_chk(string tag, logic [2:0] op, logic [1:0] idx, logic [DW-1:0] exp);
        cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx;
        #0.5;
        expect_out(tag, K_RD, exp);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and recall of preset 0
        expect_out("R1 busy after reset", K_BUSY, 10'h0);
        expect_out("R1 wiper recalled", K_WIPER, 10'h155);
        // R4: combinational reads
        read_chk("R4 read wiper", RD_W, 2'd0, 10'h155);
        read_chk("R4 read preset2", RD_P, 2'd2, 10'h3FF);
        read_chk("R4 read preset3", RD_P, 2'd3, 10'h000);
        read_chk("R4 non-read op gives zero", LD_W, 2'd1, 10'h000);
        // R2: direct wiper writes at both ends
        issue(WR_W, 2'd0, 10'h3FF);
        expect_out("R2 wiper high end", K_WIPER, 10'h3FF);
        issue(WR_W, 2'd0, 10'h000);
        expect_out("R2 wiper low end", K_WIPER, 10'h000);
        // R3: load preset into wiper
        issue(LD_W, 2'd1, 10'h000);
        expect_out("R3 load preset1", K_WIPER, 10'h2AA);
        // R5, R8: store cycle with commands during busy
        issue(WR_P, 2'd3, 10'h1C3);
        expect_out("R5 busy raised", K_BUSY, 10'h1);
        read_chk("R8 read while busy", RD_P, 2'd3, 10'h000);
        issue(WR_W, 2'd0, 10'h011);
        expect_out("R8 wiper write ignored", K_WIPER, 10'h2AA);
        n = 1;
        while (busy) begin
            n++;
            @(negedge clk);
        end
        chk_val("R5 busy length", n, NV);
        read_chk("R5 preset3 committed", RD_P, 2'd3, 10'h1C3);
        read_chk("R5 preset0 untouched", RD_P, 2'd0, 10'h155);
        // R7: write protect
        wp_n = 1'b0;
        issue(SV_W, 2'd1, 10'h000);
        expect_out("R7 save blocked no busy", K_BUSY, 10'h0);
        issue(WR_P, 2'd1, 10'h0AB);
        expect_out("R7 write blocked no busy", K_BUSY, 10'h0);
        read_chk("R7 preset1 unchanged", RD_P, 2'd1, 10'h2AA);
        wp_n = 1'b1;
        // R6: save wiper into preset
        issue(WR_W, 2'd0, 10'h0F0);
        issue(SV_W, 2'd2, 10'h3C3);
        expect_out("R6 save busy", K_BUSY, 10'h1);
        wait_idle();
        read_chk("R6 preset2 holds wiper", RD_P, 2'd2, 10'h0F0);
        // R9: reset in the middle of a store
        issue(WR_P, 2'd0, 10'h200);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        expect_out("R9 busy cleared", K_BUSY, 10'h0);
        read_chk("R9 preset0 kept", RD_P, 2'd0, 10'h155);
        expect_out("R1 wiper recall after reset", K_WIPER, 10'h155);
        // R1: recall picks up a newly stored preset 0
        issue(WR_P, 2'd0, 10'h3FF);
        wait_idle();
        issue(LD_W, 2'd3, 10'h000);
        expect_out("R3 load preset3", K_WIPER, 10'h1C3);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        expect_out("R1 recall of stored preset0", K_WIPER, 10'h3FF);
        @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule